// File: doc/BRIEF.md
# Core Clock Gear and Power-Mode Controller

This block takes one system clock and produces two synchronous clock enables: one for the CPU core and one for the peripherals. The core enable is divided by a programmable power-of-two gear. The block also runs a three-state power-mode machine with the states run, halt and sleep. In halt, only the core enable is withheld. In sleep, both enables are withheld. Leaving sleep puts the clock-source selection back to a fixed default.

Software-side writes come in as one-cycle strobes with data. There are four fields: core gear, peripheral clock enable, clock source and high-speed oscillator enable. The clock-source and oscillator-enable fields are held here and passed to the outputs; actual oscillator switching happens elsewhere. Halt and sleep requests are one-cycle pulses. Wake events are the NMI, maskable interrupt and external interrupt lines.

Top module: `clkgear_pm_ctrl`

## Requirements
- R1: With gear field value g (0 → 1/1, 1 → 1/2, 2 → 1/4, 3 → 1/8; reset value 0), `core_ce` in run mode is a one-cycle pulse exactly once every 2^g system clocks.
- R2: A gear write takes effect at the next divider wrap. Every gap between consecutive `core_ce` pulses after the write equals either the old ratio or the new ratio, and from the second gap onward it is the new ratio.
- R3: In halt mode `core_ce` stays low. `periph_ce` keeps following the peripheral enable field, including writes made during halt.
- R4: Halt ends in the cycle after `nmi`, `irq` or `ext_irq` is high, and the mode returns to run. Gear, clock-source and oscillator-enable values are the same as before halt.
- R5: In sleep mode `core_ce` and `periph_ce` are both low. `nmi`, `irq` and `halt_req` have no effect in sleep. Only `ext_irq` returns the mode to run, in the next cycle.
- R6: When sleep is left, `hs_osc_en` becomes 1 and `clk_src` becomes 0, whatever was written before.
- R7: The peripheral enable field has reset value 3. Value 3 makes `periph_ce` high on every system clock in run and halt; it is never divided. Value 0 holds `periph_ce` low.
- R8: A write of 1 or 2 to the peripheral enable field is ignored, and `periph_ce` keeps its previous behaviour.
- R9: On return to run from halt or sleep, the first `core_ce` pulse comes in the 2^g-th run cycle, counting the first run cycle as 1.
- R10: `mode` encodes run as 0, halt as 1 and sleep as 2, and never shows 3. Requests act only in run. If sleep and halt are requested in the same cycle, sleep wins.
- R11: After reset `clk_src` is 0 and `hs_osc_en` is 1. A write to either field appears on its output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | One-cycle request to enter halt |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| nmi | input | 1 | Non-maskable interrupt; wakes from halt |
| irq | input | 1 | Maskable interrupt; wakes from halt |
| ext_irq | input | 1 | External interrupt; wakes from halt or sleep |
| wr_gear | input | 1 | Write strobe for the gear field |
| wr_gear_data | input | 2 | Gear value |
| wr_pclk | input | 1 | Write strobe for the peripheral enable field |
| wr_pclk_data | input | 2 | Peripheral enable value (0 or 3) |
| wr_src | input | 1 | Write strobe for the clock-source field |
| wr_src_data | input | 2 | Clock-source value |
| wr_osc | input | 1 | Write strobe for the oscillator enable |
| wr_osc_data | input | 1 | Oscillator enable value |
| core_ce | output | 1 | Core clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| mode | output | 2 | Current power mode |
| clk_src | output | 2 | Clock-source field |
| hs_osc_en | output | 1 | High-speed oscillator enable field |

## Verification
The sweep measures gaps between `core_ce` pulses for every gear and every gear-to-gear change. A wrong divider count or a gear loaded at the wrong time therefore shows up as a wrong gap within eight cycles. A mode register stuck in the wrong state appears one cycle after the request or wake event, either on `mode` or as a missing or extra enable. A missed forced write or a missed protected write appears on `clk_src`, `hs_osc_en` or `periph_ce` in the first cycle after the event.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_HALT  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_mode_e;

  localparam logic [1:0] PCLK_ON  = 2'b11;
  localparam logic [1:0] PCLK_OFF = 2'b00;
endpackage

// File: rtl/clkgear_rst_sync.sv
module clkgear_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/clkgear_mode_fsm.sv
module clkgear_mode_fsm
  import clkgear_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halt_req,
  input  logic     sleep_req,
  input  logic     nmi,
  input  logic     irq,
  input  logic     ext_irq,
  output pm_mode_e mode_q,
  output logic     wake_from_sleep
);
  pm_mode_e mode_d;

  // Sleep wins over halt when both arrive in run.
  always_comb begin
    mode_d          = mode_q;
    wake_from_sleep = 1'b0;
    unique case (mode_q)
      PM_RUN: begin
        if (sleep_req)     mode_d = PM_SLEEP;
        else if (halt_req) mode_d = PM_HALT;
      end
      PM_HALT: begin
        if (nmi || irq || ext_irq) mode_d = PM_RUN;
      end
      PM_SLEEP: begin
        if (ext_irq) begin
          mode_d          = PM_RUN;
          wake_from_sleep = 1'b1;
        end
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_RUN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/clkgear_cfg_regs.sv
module clkgear_cfg_regs
  import clkgear_pkg::*;
#(
  parameter int          GEAR_W  = 2,
  parameter int          SRC_W   = 2,
  parameter logic [1:0]  PCLK_RST = PCLK_ON
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_force,
  input  logic              wr_gear,
  input  logic [GEAR_W-1:0] wr_gear_data,
  input  logic              wr_pclk,
  input  logic [1:0]        wr_pclk_data,
  input  logic              wr_src,
  input  logic [SRC_W-1:0]  wr_src_data,
  input  logic              wr_osc,
  input  logic              wr_osc_data,
  output logic [GEAR_W-1:0] gear_q,
  output logic [1:0]        pclk_q,
  output logic [SRC_W-1:0]  src_q,
  output logic              osc_q
);
  logic [GEAR_W-1:0] gear_d;
  logic [1:0]        pclk_d;
  logic [SRC_W-1:0]  src_d;
  logic              osc_d;
  logic              pclk_legal;

  assign pclk_legal = (wr_pclk_data == PCLK_ON) || (wr_pclk_data == PCLK_OFF);

  always_comb begin
    gear_d = wr_gear ? wr_gear_data : gear_q;
    pclk_d = (wr_pclk && pclk_legal) ? wr_pclk_data : pclk_q;
    src_d  = src_q;
    osc_d  = osc_q;
    if (wr_src) src_d = wr_src_data;
    if (wr_osc) osc_d = wr_osc_data;
    // wake from sleep overrides any same-cycle write
    if (wake_force) begin
      src_d = '0;
      osc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gear_q <= '0;
      pclk_q <= PCLK_RST;
      src_q  <= '0;
      osc_q  <= 1'b1;
    end else begin
      gear_q <= gear_d;
      pclk_q <= pclk_d;
      src_q  <= src_d;
      osc_q  <= osc_d;
    end
  end
endmodule

// File: rtl/clkgear_div.sv
module clkgear_div #(
  parameter int GEAR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [GEAR_W-1:0] gear,
  output logic              ce
);
  localparam int MAX_SHIFT = (1 << GEAR_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [GEAR_W-1:0] act_q,  act_d;
  logic [CNT_W-1:0]  last_cnt;
  logic              wrap;

  assign last_cnt = ~({CNT_W{1'b1}} << act_q);
  assign wrap     = run && (cnt_q == last_cnt);
  assign ce       = wrap;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!run) begin
      cnt_d = '0;
      act_d = gear;
    end else if (wrap) begin
      cnt_d = '0;
      act_d = gear;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/clkgear_pm_ctrl.sv
module clkgear_pm_ctrl
  import clkgear_pkg::*;
#(
  parameter int GEAR_W = 2,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic              sleep_req,
  input  logic              nmi,
  input  logic              irq,
  input  logic              ext_irq,
  input  logic              wr_gear,
  input  logic [GEAR_W-1:0] wr_gear_data,
  input  logic              wr_pclk,
  input  logic [1:0]        wr_pclk_data,
  input  logic              wr_src,
  input  logic [SRC_W-1:0]  wr_src_data,
  input  logic              wr_osc,
  input  logic              wr_osc_data,
  output logic              core_ce,
  output logic              periph_ce,
  output logic [1:0]        mode,
  output logic [SRC_W-1:0]  clk_src,
  output logic              hs_osc_en
);
  logic              srst_n;
  pm_mode_e          mode_q;
  logic              wake_force;
  logic [GEAR_W-1:0] gear_q;
  logic [1:0]        pclk_q;

  clkgear_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  clkgear_mode_fsm u_fsm (
    .clk(clk), .rst_n(srst_n),
    .halt_req(halt_req), .sleep_req(sleep_req),
    .nmi(nmi), .irq(irq), .ext_irq(ext_irq),
    .mode_q(mode_q), .wake_from_sleep(wake_force)
  );

  clkgear_cfg_regs #(.GEAR_W(GEAR_W), .SRC_W(SRC_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .wake_force(wake_force),
    .wr_gear(wr_gear), .wr_gear_data(wr_gear_data),
    .wr_pclk(wr_pclk), .wr_pclk_data(wr_pclk_data),
    .wr_src(wr_src), .wr_src_data(wr_src_data),
    .wr_osc(wr_osc), .wr_osc_data(wr_osc_data),
    .gear_q(gear_q), .pclk_q(pclk_q), .src_q(clk_src), .osc_q(hs_osc_en)
  );

  clkgear_div #(.GEAR_W(GEAR_W)) u_div (
    .clk(clk), .rst_n(srst_n),
    .run(mode_q == PM_RUN), .gear(gear_q), .ce(core_ce)
  );

  assign periph_ce = (mode_q != PM_SLEEP) && (pclk_q == PCLK_ON);
  assign mode      = mode_q;
endmodule

// File: rtl/clkgear_pm_chk.sv
module clkgear_pm_chk #(
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             nmi,
  input logic             irq,
  input logic             ext_irq,
  input logic             wr_pclk,
  input logic [1:0]       wr_pclk_data,
  input logic             wr_src,
  input logic             wr_osc,
  input logic             core_ce,
  input logic             periph_ce,
  input logic [1:0]       mode,
  input logic [SRC_W-1:0] clk_src,
  input logic             hs_osc_en
);
  // R3
  halt_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> !core_ce);

  // R5
  sleep_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!core_ce && !periph_ce));

  // R5
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !ext_irq) |=> (mode == 2'd2));

  // R4
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && (nmi || irq || ext_irq)) |=> (mode == 2'd0));

  // R4
  halt_keep_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !wr_src && !wr_osc) |=> ($stable(clk_src) && $stable(hs_osc_en)));

  // R6
  wake_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && ext_irq) |=> (mode == 2'd0 && hs_osc_en && clk_src == '0));

  // R8
  pclk_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pclk && (wr_pclk_data == 2'd1 || wr_pclk_data == 2'd2) && mode == 2'd0 && !sleep_req)
    |=> (periph_ce == $past(periph_ce)));

  // R10
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

bind clkgear_pm_ctrl clkgear_pm_chk #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
  .nmi(nmi), .irq(irq), .ext_irq(ext_irq),
  .wr_pclk(wr_pclk), .wr_pclk_data(wr_pclk_data),
  .wr_src(wr_src), .wr_osc(wr_osc),
  .core_ce(core_ce), .periph_ce(periph_ce), .mode(mode),
  .clk_src(clk_src), .hs_osc_en(hs_osc_en)
);

// File: tb/clkgear_pm_ctrl_tb.sv
`timescale 1ns/1ps
module clkgear_pm_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, nmi = 0, irq = 0, ext_irq = 0;
  logic wr_gear = 0, wr_pclk = 0, wr_src = 0, wr_osc = 0;
  logic [1:0] wr_gear_data = 0, wr_pclk_data = 0, wr_src_data = 0;
  logic wr_osc_data = 0;
  logic core_ce, periph_ce, hs_osc_en;
  logic [1:0] mode, clk_src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkgear_pm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .nmi(nmi), .irq(irq), .ext_irq(ext_irq),
    .wr_gear(wr_gear), .wr_gear_data(wr_gear_data),
    .wr_pclk(wr_pclk), .wr_pclk_data(wr_pclk_data),
    .wr_src(wr_src), .wr_src_data(wr_src_data),
    .wr_osc(wr_osc), .wr_osc_data(wr_osc_data),
    .core_ce(core_ce), .periph_ce(periph_ce), .mode(mode),
    .clk_src(clk_src), .hs_osc_en(hs_osc_en)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_gear(int g);
    wr_gear = 1; wr_gear_data = g[1:0]; cyc(); wr_gear = 0;
  endtask
  task automatic set_pclk(int v);
    wr_pclk = 1; wr_pclk_data = v[1:0]; cyc(); wr_pclk = 0;
  endtask
  task automatic set_src(int v);
    wr_src = 1; wr_src_data = v[1:0]; cyc(); wr_src = 0;
  endtask
  task automatic set_osc(int v);
    wr_osc = 1; wr_osc_data = v[0]; cyc(); wr_osc = 0;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 40; i++) begin
      if (core_ce) break;
      cyc();
    end
  endtask

  // gap to next pulse; also counts periph_ce cycles over the gap
  task automatic gap(output int n, output int pc);
    cyc(); n = 1; pc = periph_ce;
    while (!core_ce && n < 40) begin cyc(); n++; pc += periph_ce; end
  endtask

  task automatic first_pulse(output int n);
    n = 1;
    while (!core_ce && n < 40) begin cyc(); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, pc;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();
    // R11 R7 R1 R10 reset state
    chk("R10 reset mode", mode, 0);
    chk("R11 reset clk_src", clk_src, 0);
    chk("R11 reset hs_osc_en", hs_osc_en, 1);
    chk("R7 reset periph_ce", periph_ce, 1);
    chk("R1 reset gear core_ce", core_ce, 1);

    // R1 R7 gear sweep
    for (int g = 0; g < 4; g++) begin
      set_gear(g);
      repeat (10) cyc();
      wait_pulse();
      for (int k = 0; k < 3; k++) begin
        gap(n, pc);
        chk($sformatf("R1 gap gear %0d", g), n, 1 << g);
        chk($sformatf("R7 periph every cycle gear %0d", g), pc, n);
      end
    end

    // R2 gear changes between every pair
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 4; w++) begin
        set_gear(o);
        repeat (10) cyc();
        wait_pulse();
        set_gear(w);
        for (int k = 0; k < 3; k++) begin
          wait_pulse();
          gap(n, pc);
          if (k == 0)
            chk($sformatf("R2 first gap %0d->%0d", o, w),
                (n == (1 << o) || n == (1 << w)) ? 1 : 0, 1);
          else
            chk($sformatf("R2 later gap %0d->%0d", o, w), n, 1 << w);
        end
      end
    end

    // R11 writes
    set_src(1);
    chk("R11 clk_src write", clk_src, 1);
    set_osc(0);
    chk("R11 osc write", hs_osc_en, 0);

    // R3 R4 R9 halt with each wake source and each gear
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 3; s++) begin
        set_gear(g);
        repeat (10) cyc();
        halt_req = 1; cyc(); halt_req = 0;
        chk("R10 halt mode", mode, 1);
        pc = 0; n = 0;
        for (int i = 0; i < 6; i++) begin
          n += core_ce; pc += periph_ce; cyc();
        end
        chk("R3 core off in halt", n, 0);
        chk("R3 periph on in halt", pc, 6);
        if (s == 0) nmi = 1; else if (s == 1) irq = 1; else ext_irq = 1;
        cyc();
        nmi = 0; irq = 0; ext_irq = 0;
        chk($sformatf("R4 halt exit src %0d", s), mode, 0);
        chk("R4 clk_src kept", clk_src, 1);
        chk("R4 osc kept", hs_osc_en, 0);
        first_pulse(n);
        chk($sformatf("R9 R4 first pulse after halt gear %0d", g), n, 1 << g);
      end
    end

    // R3 peripheral field written during halt
    halt_req = 1; cyc(); halt_req = 0;
    set_pclk(0);
    chk("R3 periph off by write in halt", periph_ce, 0);
    set_pclk(3);
    chk("R3 periph on by write in halt", periph_ce, 1);
    sleep_req = 1; cyc(); sleep_req = 0;
    chk("R10 sleep ignored in halt", mode, 1);
    irq = 1; cyc(); irq = 0;

    // R5 R6 R9 sleep for each gear
    for (int g = 0; g < 4; g++) begin
      set_gear(g);
      set_src(2);
      set_osc(0);
      repeat (5) cyc();
      sleep_req = 1; cyc(); sleep_req = 0;
      chk("R10 sleep mode", mode, 2);
      chk("R5 core off in sleep", core_ce, 0);
      chk("R5 periph off in sleep", periph_ce, 0);
      nmi = 1; cyc(); nmi = 0;
      chk("R5 nmi ignored in sleep", mode, 2);
      irq = 1; cyc(); irq = 0;
      chk("R5 irq ignored in sleep", mode, 2);
      halt_req = 1; cyc(); halt_req = 0;
      chk("R5 halt ignored in sleep", mode, 2);
      chk("R5 periph still off", periph_ce, 0);
      ext_irq = 1; cyc(); ext_irq = 0;
      chk("R5 ext wakes", mode, 0);
      chk("R6 osc forced", hs_osc_en, 1);
      chk("R6 src forced", clk_src, 0);
      chk("R5 periph back", periph_ce, 1);
      first_pulse(n);
      chk($sformatf("R9 first pulse after sleep gear %0d", g), n, 1 << g);
    end

    // R10 simultaneous requests
    halt_req = 1; sleep_req = 1; cyc(); halt_req = 0; sleep_req = 0;
    chk("R10 sleep wins", mode, 2);
    ext_irq = 1; cyc(); ext_irq = 0;

    // R8 prohibited writes, R7 off value
    set_pclk(1);
    chk("R8 write 1 ignored (on)", periph_ce, 1);
    set_pclk(2);
    chk("R8 write 2 ignored (on)", periph_ce, 1);
    set_pclk(0);
    chk("R7 off value", periph_ce, 0);
    set_pclk(1);
    chk("R8 write 1 ignored (off)", periph_ce, 0);
    set_pclk(2);
    chk("R8 write 2 ignored (off)", periph_ce, 0);
    set_pclk(3);
    chk("R7 on value", periph_ce, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule